// File: doc/BRIEF.md
# Card Busy-End Detector with Busy Timeout

This block sits beside the command path of an SD/MMC host. Some command responses are followed by a busy phase, during which the card holds DAT0 low. The command path pulses a start input when it issues such a command and pulses a response input once the response has arrived. From the response onward the block watches a synchronised copy of DAT0. It records the return to not-busy in a sticky flag and pulses a completion output. A data timer is loaded when the command starts and counts card-clock enables for the whole wait. If the card stays busy for too long, the timer raises a sticky data-timeout flag instead.

Software sees four word registers. Word 0 is status (read only). Word 1 is the interrupt mask. Word 2 is the clear register (write one to clear; it reads as zero). Word 3 holds the timer load value in card-clock ticks. A load value of zero selects a default that the block computes from a default timeout in milliseconds and the card clock rate in kHz. A command CRC failure or a command timeout, each given as a one-cycle input pulse, ends a wait without reporting completion. One interrupt line combines the sticky flags with their mask bits.

Top module: `busy_end_detect`

## Requirements
- R1: Status bit 20 shows the inverse of DAT0 after a two-flop synchroniser: it reads 1 two clock edges after DAT0 goes low. It never drives the interrupt, and mask bit 20 cannot be set.
- R2: Status bit 21 is sticky. It is set when the synchronised DAT0 returns from busy to not-busy during a busy wait, that is, after a response was received while DAT0 was low.
- R3: irq_o is the OR of status bit 21 ANDed with mask bit 21 and status bit 2 ANDed with mask bit 2. Only mask bits 2 and 21 hold a value.
- R4: Writing word 2 clears each sticky status bit whose data bit is 1. Bits written as 0 leave the flags unchanged. A flag that is set and cleared in the same cycle ends up set.
- R5: The timer is loaded from word 3 on cmd_start_i and decrements on each card-clock enable until the wait ends. It stops at zero. Reaching zero during a wait sets sticky status bit 2 and ends the wait, with no bit 21 and no done_o.
- R6: A word-3 value of zero loads DEF_MS*CCLK_KHZ ticks. Word 3 reads back the value that was written.
- R7: A pulse on cmd_crc_fail_i or cmd_timeout_i during a wait ends the wait, with no done_o and no status bit 21.
- R8: If DAT0 is not busy when resp_done_i is pulsed, done_o pulses on the next edge, no busy phase is entered and status bit 21 stays clear.
- R9: At the end of busy, done_o is a one-cycle pulse issued on the same edge that sets status bit 21.
- R10: Changes on DAT0 while no wait is active do not set status bit 21.
- R11: Undefined status bits, mask bits and the clear word read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cclk_en_i | input | 1 | One pulse per card-clock cycle; advances the timer |
| dat0_i | input | 1 | Raw DAT0 line; low means busy |
| cmd_start_i | input | 1 | Pulse: a command whose response expects busy was issued |
| resp_done_i | input | 1 | Pulse: the response was received |
| cmd_crc_fail_i | input | 1 | Pulse: response CRC failure |
| cmd_timeout_i | input | 1 | Pulse: no response in time |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |
| done_o | output | 1 | Pulse: command finished without error |

## Verification
The main function is exercised with four command shapes. A response with DAT0 already high separates immediate completion from a busy phase. A response with DAT0 low followed by release checks the end-of-busy edge, the sticky flag and the pulse. A card that never releases, with an explicit load value and with the zero default, shows that the timer fires at the programmed depth and not before. A CRC failure during busy and a command timeout before the response show that errors suppress completion. Toggling DAT0 between commands confirms that only the live flag follows it. Mask and clear writes with mixed bit patterns separate gating from clearing.

// File: rtl/busy_end_pkg.sv
package busy_end_pkg;
  localparam int unsigned BIT_DTO  = 2;
  localparam int unsigned BIT_BUSY = 20;
  localparam int unsigned BIT_BEND = 21;

  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_MASK   = 1;
  localparam int unsigned REG_CLEAR  = 2;
  localparam int unsigned REG_TIMER  = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RESP = 2'd1,
    ST_BUSY = 2'd2
  } wait_st_e;
endpackage

// File: rtl/bsy_sync.sv
module bsy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/bsy_timer.sv
module bsy_timer #(
  parameter int unsigned TW = 32,
  parameter logic [TW-1:0] DEF_TICKS = TW'(1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          run_i,
  input  logic          tick_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (load_i)                       cnt_q <= (load_val_i == '0) ? DEF_TICKS : load_val_i;
    else if (run_i && tick_i && cnt_q != '0) cnt_q <= cnt_q - TW'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R5
  stop_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

  // R6
  default_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i == '0) |=> (cnt_q == DEF_TICKS));
endmodule

// File: rtl/bsy_fsm.sv
module bsy_fsm
  import busy_end_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic resp_i,
  input  logic crc_i,
  input  logic tmo_i,
  input  logic busy_i,
  input  logic zero_i,
  output logic load_o,
  output logic run_o,
  output logic end_evt_o,
  output logic dto_evt_o,
  output logic done_o
);
  wait_st_e st_q, st_d;
  logic busy_d_q, fall, err, done_d, done_q;

  assign fall = busy_d_q & ~busy_i;
  assign err  = crc_i | tmo_i;

  always_comb begin
    st_d      = st_q;
    load_o    = 1'b0;
    end_evt_o = 1'b0;
    dto_evt_o = 1'b0;
    done_d    = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_RESP;
        load_o = 1'b1;
      end
      ST_RESP: begin
        if (err) st_d = ST_IDLE;
        else if (zero_i) begin
          dto_evt_o = 1'b1;
          st_d      = ST_IDLE;
        end else if (resp_i) begin
          if (busy_i) st_d = ST_BUSY;
          else begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end
      end
      ST_BUSY: begin
        if (err) st_d = ST_IDLE;
        else if (zero_i) begin
          dto_evt_o = 1'b1;
          st_d      = ST_IDLE;
        end else if (fall) begin
          end_evt_o = 1'b1;
          done_d    = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      busy_d_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      busy_d_q <= busy_i;
      done_q   <= done_d;
    end
  end

  assign run_o  = (st_q != ST_IDLE);
  assign done_o = done_q;

  // R7
  err_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q != ST_IDLE) && (crc_i || tmo_i)) |=> (st_q == ST_IDLE && !done_o));

  // R8
  no_busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RESP && resp_i && !busy_i && !crc_i && !tmo_i && !zero_i) |=> done_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  idle_no_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !end_evt_o);
endmodule

// File: rtl/bsy_regs.sv
module bsy_regs
  import busy_end_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned TW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  input  logic              end_evt_i,
  input  logic              dto_evt_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic [TW-1:0]     tmr_load_o
);
  logic bend_q, dto_q, msk_bend_q, msk_dto_q;
  logic [TW-1:0] tmr_q;
  logic wr_mask, wr_clr, wr_tmr;

  assign wr_mask = we_i && (addr_i == ADDR_W'(REG_MASK));
  assign wr_clr  = we_i && (addr_i == ADDR_W'(REG_CLEAR));
  assign wr_tmr  = we_i && (addr_i == ADDR_W'(REG_TIMER));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bend_q     <= 1'b0;
      dto_q      <= 1'b0;
      msk_bend_q <= 1'b0;
      msk_dto_q  <= 1'b0;
      tmr_q      <= '0;
    end else begin
      // set has priority over a same-cycle clear
      if (end_evt_i)                       bend_q <= 1'b1;
      else if (wr_clr && wdata_i[BIT_BEND]) bend_q <= 1'b0;
      if (dto_evt_i)                       dto_q  <= 1'b1;
      else if (wr_clr && wdata_i[BIT_DTO])  dto_q  <= 1'b0;
      if (wr_mask) begin
        msk_bend_q <= wdata_i[BIT_BEND];
        msk_dto_q  <= wdata_i[BIT_DTO];
      end
      if (wr_tmr) tmr_q <= wdata_i[TW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_STATUS)) begin
      rdata_o[BIT_DTO]  = dto_q;
      rdata_o[BIT_BUSY] = busy_i;
      rdata_o[BIT_BEND] = bend_q;
    end else if (addr_i == ADDR_W'(REG_MASK)) begin
      rdata_o[BIT_DTO]  = msk_dto_q;
      rdata_o[BIT_BEND] = msk_bend_q;
    end else if (addr_i == ADDR_W'(REG_TIMER)) begin
      rdata_o[TW-1:0] = tmr_q;
    end
  end

  assign irq_o      = (bend_q & msk_bend_q) | (dto_q & msk_dto_q);
  assign tmr_load_o = tmr_q;

  // R2
  bend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_evt_i |=> bend_q);

  // R5
  dto_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dto_evt_i |=> dto_q);

  // R4
  bend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && wdata_i[BIT_BEND] && !end_evt_i) |=> !bend_q);

  // R4
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bend_q && !wr_clr) |=> bend_q);
endmodule

// File: rtl/busy_end_detect.sv
module busy_end_detect
  import busy_end_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned TIMER_W     = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEF_MS      = 10000,
  parameter int unsigned CCLK_KHZ    = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cclk_en_i,
  input  logic              dat0_i,
  input  logic              cmd_start_i,
  input  logic              resp_done_i,
  input  logic              cmd_crc_fail_i,
  input  logic              cmd_timeout_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              done_o
);
  localparam logic [TIMER_W-1:0] DEF_TICKS = TIMER_W'(DEF_MS * CCLK_KHZ);

  logic dat0_s, busy_live;
  logic load, run, zero, end_evt, dto_evt;
  logic [TIMER_W-1:0] tmr_load;

  bsy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dat0_i), .q_o(dat0_s)
  );

  assign busy_live = ~dat0_s;

  bsy_timer #(.TW(TIMER_W), .DEF_TICKS(DEF_TICKS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(tmr_load),
    .run_i(run), .tick_i(cclk_en_i), .zero_o(zero)
  );

  bsy_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cmd_start_i), .resp_i(resp_done_i),
    .crc_i(cmd_crc_fail_i), .tmo_i(cmd_timeout_i), .busy_i(busy_live), .zero_i(zero),
    .load_o(load), .run_o(run), .end_evt_o(end_evt), .dto_evt_o(dto_evt), .done_o(done_o)
  );

  bsy_regs #(.ADDR_W(ADDR_W), .TW(TIMER_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .busy_i(busy_live), .end_evt_i(end_evt), .dto_evt_i(dto_evt),
    .rdata_o(reg_rdata_o), .irq_o(irq_o), .tmr_load_o(tmr_load)
  );

  // R1
  live_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($changed(busy_live) && !end_evt && !dto_evt && !reg_we_i) |=> $stable(irq_o));
endmodule

// File: tb/tb_busy_end_detect.sv
`timescale 1ns/1ps
module tb_busy_end_detect;
  localparam logic [31:0] B_DTO  = 32'h1 << 2;
  localparam logic [31:0] B_BUSY = 32'h1 << 20;
  localparam logic [31:0] B_BEND = 32'h1 << 21;

  logic clk = 1'b0, rst_n = 1'b0, cclk_en = 1'b0, dat0 = 1'b1;
  logic start = 1'b0, resp = 1'b0, crc = 1'b0, tmo = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic irq, done;

  int checks = 0, fails = 0, done_cnt = 0;
  logic mon_req = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  busy_end_detect #(.DEF_MS(50), .CCLK_KHZ(1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cclk_en_i(cclk_en), .dat0_i(dat0),
    .cmd_start_i(start), .resp_done_i(resp), .cmd_crc_fail_i(crc),
    .cmd_timeout_i(tmo), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .done_o(done)
  );

  always @(posedge clk) #1 cclk_en <= ~cclk_en;

  // monitor: scoreboard pop and done counter
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (mon_req && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: got %h exp %h", t, rdata, e);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic chk_reg(logic [1:0] a, logic [31:0] e, string t);
    addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    mon_req = 1'b1;
    tick();
    mon_req = 1'b0;
  endtask

  task automatic chk_val(logic [31:0] got, logic [31:0] e, string t);
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s: got %h exp %h", t, got, e);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    tick();
    s = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got hang exp finish");
    summary();
    $finish;
  end

  initial begin
    int d0;
    tick(3);
    rst_n = 1'b1;
    tick();
    // reset state, R11
    chk_reg(2'd0, 32'h0, "R11 status after reset");
    chk_reg(2'd1, 32'h0, "R11 mask after reset");
    chk_reg(2'd3, 32'h0, "R6 timer after reset");
    chk_val(32'(irq), 32'h0, "R3 irq after reset");

    // R1 live flag, R10 idle toggle
    dat0 = 1'b0; tick(3);
    chk_reg(2'd0, B_BUSY, "R1 live busy");
    wr(2'd1, 32'hFFFF_FFFF);
    chk_reg(2'd1, B_BEND | B_DTO, "R11 mask bits");
    chk_val(32'(irq), 32'h0, "R1 live bit no irq");
    chk_reg(2'd2, 32'h0, "R11 clear word reads zero");
    dat0 = 1'b1; tick(4);
    chk_reg(2'd0, 32'h0, "R10 idle release no end flag");

    // R8 no busy phase
    wr(2'd3, 32'd1000);
    chk_reg(2'd3, 32'd1000, "R6 timer readback");
    d0 = done_cnt;
    pulse(start); tick(2); pulse(resp); tick(3);
    chk_val(32'(done_cnt - d0), 32'd1, "R8 immediate done");
    chk_reg(2'd0, 32'h0, "R8 no end flag");

    // R2/R9 busy end
    d0 = done_cnt;
    pulse(start); dat0 = 1'b0; tick(3); pulse(resp); tick(5);
    chk_reg(2'd0, B_BUSY, "R2 still busy no flag");
    chk_val(32'(done_cnt - d0), 32'd0, "R9 no done while busy");
    dat0 = 1'b1; tick(4);
    chk_reg(2'd0, B_BEND, "R2 end flag set");
    chk_val(32'(done_cnt - d0), 32'd1, "R9 single done pulse");
    chk_val(32'(irq), 32'h1, "R3 irq masked in");
    wr(2'd1, 32'h0);
    chk_val(32'(irq), 32'h0, "R3 irq masked out");
    wr(2'd1, B_BEND | B_DTO);

    // R4 clear
    wr(2'd2, ~B_BEND);
    chk_reg(2'd0, B_BEND, "R4 zero bits no clear");
    wr(2'd2, B_BEND);
    chk_reg(2'd0, 32'h0, "R4 w1c clears");
    chk_val(32'(irq), 32'h0, "R4 irq drops");

    // R5 timeout
    d0 = done_cnt;
    wr(2'd3, 32'd20);
    pulse(start); dat0 = 1'b0; tick(3); pulse(resp); tick(26);
    chk_reg(2'd0, B_BUSY, "R5 no early timeout");
    tick(30);
    chk_reg(2'd0, B_BUSY | B_DTO, "R5 timeout flag");
    chk_val(32'(irq), 32'h1, "R3 irq on timeout");
    dat0 = 1'b1; tick(4);
    chk_reg(2'd0, B_DTO, "R5 no end after timeout");
    chk_val(32'(done_cnt - d0), 32'd0, "R5 no done after timeout");
    wr(2'd2, B_DTO);

    // R6 default load
    wr(2'd3, 32'd0);
    chk_reg(2'd3, 32'd0, "R6 zero readback");
    pulse(start); dat0 = 1'b0; tick(3); pulse(resp); tick(60);
    chk_reg(2'd0, B_BUSY, "R6 default not expired early");
    tick(60);
    chk_reg(2'd0, B_BUSY | B_DTO, "R6 default expiry");
    dat0 = 1'b1; tick(4);
    wr(2'd2, B_DTO);
    chk_reg(2'd0, 32'h0, "R4 timeout flag cleared");

    // R7 crc fail during busy
    d0 = done_cnt;
    wr(2'd3, 32'd1000);
    pulse(start); dat0 = 1'b0; tick(3); pulse(resp); tick(2);
    pulse(crc); tick();
    dat0 = 1'b1; tick(4);
    chk_reg(2'd0, 32'h0, "R7 crc abort no end flag");
    // R7 command timeout before response
    pulse(start); pulse(tmo); pulse(resp);
    tick(2);
    chk_val(32'(done_cnt - d0), 32'd0, "R7 no done after errors");
    dat0 = 1'b0; tick(3); dat0 = 1'b1; tick(4);
    chk_reg(2'd0, 32'h0, "R10 toggle after abort ignored");

    // R8 again after errors
    pulse(start); tick(); pulse(resp); tick(3);
    chk_val(32'(done_cnt - d0), 32'd1, "R8 done after recovery");

    tick(2);
    summary();
    $finish;
  end
endmodule